// File: doc/BRIEF.md
# Boot Stream Header and Block Parser

This block sits behind an 8-bit boot interface and turns the raw byte stream into configuration values and memory write requests. Bytes come in on a valid/ready handshake and are paired into 16-bit words, low byte first. The first word is a key that confirms an 8-bit memory width. If the key is wrong, the parser stops and raises an error flag.

After the key, the parser captures a fixed header:

- a prescaler byte, followed by one pad byte;
- a clock-high count and a clock-low count;
- a run of reserved words, which are skipped;
- a 23-bit entry point, sent as two words.

The parser then walks a sequence of blocks. Each block carries a word count, a 32-bit destination address and the data words. Each data word becomes one request on the write port. A block whose count is zero ends the stream and raises the done flag.

The write port is a valid/ready output that holds one request at a time. While a request is waiting for `wr_ready`, `in_ready` is held low. As a result, the input side stalls instead of dropping or repeating bytes. Once done or error is raised, `in_ready` stays low until reset.

Top module: `boot_stream_parser`

## Requirements
- R1: After reset, `in_ready` is 1. `wr_valid`, `done` and `error` are 0, and every configuration output is 0.
- R2: Bytes are paired low byte first. The first word must equal 0x08AA, which means byte 0xAA and then byte 0x08. Any other first word sets `error` on the clock edge that accepts its second byte. `error` then stays at 1 and `in_ready` stays at 0.
- R3: The third byte is captured on `cfg_prescale`. The fourth byte has no effect on any output.
- R4: Bytes 5-6 form `cfg_clk_high` and bytes 7-8 form `cfg_clk_low`, each low byte first.
- R5: The eight words that follow the clock-low count change no output.
- R6: The entry point comes as an upper word and then a lower word. `cfg_entry` is {upper[6:0], lower[15:0]}, and upper bits 15:7 are ignored.
- R7: Each block is a size word, then the address upper word, then the address lower word, then size data words. Data word k of a block is written at address+k, so the address carries across 16-bit boundaries.
- R8: A size word of 0x0000 sets `done` on the edge that accepts its second byte. `done` then stays at 1 and `in_ready` stays at 0.
- R9: While `wr_valid` is 1, `in_ready` is 0. `wr_addr` and `wr_data` hold steady until `wr_ready` is seen. Every data word appears on the write port exactly once, in stream order.
- R10: Once `done` or `error` is 1, no write request is raised and the configuration outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| cfg_prescale | output | 8 | Captured prescaler |
| cfg_clk_high | output | 16 | Captured clock-high count |
| cfg_clk_low | output | 16 | Captured clock-low count |
| cfg_entry | output | 23 | Captured entry point |
| wr_addr | output | 32 | Write request address |
| wr_data | output | 16 | Write request data |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Memory takes the request |
| done | output | 1 | Stream ended with a zero-size block |
| error | output | 1 | Key mismatch, parsing halted |

## Verification
A clean stream is sent with distinct non-zero bytes in every header slot and a non-zero pad byte. This separates byte-order mistakes and off-by-one slot decoding from correct capture. The same stream carries an entry upper word with bit 7 set, so a wrong entry mask shows up. It also carries a block that starts at 0x0001FFFE, so a missing carry in the address counter shows up.

The stream is sent once with `wr_ready` toggling and once with it held low for many cycles. A scoreboard compares every write against the expected address and data, which exposes lost or duplicated words under backpressure.

Two bad keys are tried: a wrong value, and the right bytes in swapped order. These show that the error path stops the parser and leaves the configuration untouched.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  typedef enum logic [3:0] {
    ST_KEY,
    ST_PSC,
    ST_CKH,
    ST_CKL,
    ST_RSV,
    ST_EPH,
    ST_EPL,
    ST_SIZE,
    ST_ADH,
    ST_ADL,
    ST_DATA,
    ST_DONE,
    ST_ERR
  } pst_e;

  localparam logic [15:0] KEY_WORD = 16'h08AA;

endpackage

// File: rtl/bsp_word_pack.sv
module bsp_word_pack #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_fire,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic                word_fire,
  output logic [2*BYTE_W-1:0] word_out
);

  logic [BYTE_W-1:0] lo_q;
  logic              have_lo_q;

  // the second byte completes the word in the same cycle it is accepted
  assign word_fire = byte_fire & have_lo_q;
  assign word_out  = {byte_in, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q      <= '0;
      have_lo_q <= 1'b0;
    end else if (byte_fire) begin
      if (!have_lo_q) lo_q <= byte_in;
      have_lo_q <= ~have_lo_q;
    end
  end

endmodule

// File: rtl/bsp_hdr_fsm.sv
module bsp_hdr_fsm
  import bsp_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int PSC_W     = 8,
  parameter int RSV_WORDS = 8,
  parameter int EP_HI_W   = 7,
  localparam int ADDR_W   = 2 * WORD_W,
  localparam int ENTRY_W  = WORD_W + EP_HI_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_fire,
  input  logic [WORD_W-1:0]  word,
  output logic               halted,
  output logic               is_done,
  output logic               is_err,
  output logic [PSC_W-1:0]   cfg_prescale,
  output logic [WORD_W-1:0]  cfg_clk_high,
  output logic [WORD_W-1:0]  cfg_clk_low,
  output logic [ENTRY_W-1:0] cfg_entry,
  output logic               req,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [WORD_W-1:0]  req_data
);

  localparam int RC_W = (RSV_WORDS > 1) ? $clog2(RSV_WORDS) : 1;

  pst_e               st_q;
  logic [RC_W-1:0]    rsv_q;
  logic [EP_HI_W-1:0] ep_hi_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [WORD_W-1:0]  remain_q;

  assign is_done  = (st_q == ST_DONE);
  assign is_err   = (st_q == ST_ERR);
  assign halted   = is_done | is_err;
  assign req      = word_fire && (st_q == ST_DATA);
  assign req_addr = addr_q;
  assign req_data = word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_KEY;
      rsv_q        <= '0;
      ep_hi_q      <= '0;
      addr_q       <= '0;
      remain_q     <= '0;
      cfg_prescale <= '0;
      cfg_clk_high <= '0;
      cfg_clk_low  <= '0;
      cfg_entry    <= '0;
    end else if (word_fire) begin
      unique case (st_q)
        ST_KEY:  st_q <= (word == KEY_WORD) ? ST_PSC : ST_ERR;
        ST_PSC: begin
          cfg_prescale <= word[PSC_W-1:0];
          st_q         <= ST_CKH;
        end
        ST_CKH: begin
          cfg_clk_high <= word;
          st_q         <= ST_CKL;
        end
        ST_CKL: begin
          cfg_clk_low <= word;
          rsv_q       <= '0;
          st_q        <= (RSV_WORDS == 0) ? ST_EPH : ST_RSV;
        end
        ST_RSV: begin
          rsv_q <= rsv_q + 1'b1;
          if (rsv_q == RC_W'(RSV_WORDS - 1)) st_q <= ST_EPH;
        end
        ST_EPH: begin
          ep_hi_q <= word[EP_HI_W-1:0];
          st_q    <= ST_EPL;
        end
        ST_EPL: begin
          cfg_entry <= {ep_hi_q, word};
          st_q      <= ST_SIZE;
        end
        ST_SIZE: begin
          remain_q <= word;
          st_q     <= (word == '0) ? ST_DONE : ST_ADH;
        end
        ST_ADH: begin
          addr_q[ADDR_W-1:WORD_W] <= word;
          st_q                    <= ST_ADL;
        end
        ST_ADL: begin
          addr_q[WORD_W-1:0] <= word;
          st_q               <= ST_DATA;
        end
        ST_DATA: begin
          addr_q   <= addr_q + 1'b1;
          remain_q <= remain_q - 1'b1;
          if (remain_q == WORD_W'(1)) st_q <= ST_SIZE;
        end
        default: st_q <= st_q;
      endcase
    end
  end

endmodule

// File: rtl/bsp_wr_port.sv
module bsp_wr_port #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (req) begin
      wr_valid <= 1'b1;
      wr_addr  <= req_addr;
      wr_data  <= req_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/boot_stream_parser.sv
module boot_stream_parser #(
  parameter int RSV_WORDS = 8,
  parameter int EP_HI_W   = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [7:0]  cfg_prescale,
  output logic [15:0] cfg_clk_high,
  output logic [15:0] cfg_clk_low,
  output logic [22:0] cfg_entry,
  output logic [31:0] wr_addr,
  output logic [15:0] wr_data,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic        done,
  output logic        error
);

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 2 * WORD_W;

  logic              byte_fire;
  logic              word_fire;
  logic [WORD_W-1:0] word;
  logic              halted;
  logic              req;
  logic [ADDR_W-1:0] req_addr;
  logic [WORD_W-1:0] req_data;

  assign in_ready  = ~halted & ~wr_valid;
  assign byte_fire = in_valid & in_ready;

  bsp_word_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_fire (byte_fire),
    .byte_in   (in_data),
    .word_fire (word_fire),
    .word_out  (word)
  );

  bsp_hdr_fsm #(
    .WORD_W    (WORD_W),
    .PSC_W     (BYTE_W),
    .RSV_WORDS (RSV_WORDS),
    .EP_HI_W   (EP_HI_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_fire    (word_fire),
    .word         (word),
    .halted       (halted),
    .is_done      (done),
    .is_err       (error),
    .cfg_prescale (cfg_prescale),
    .cfg_clk_high (cfg_clk_high),
    .cfg_clk_low  (cfg_clk_low),
    .cfg_entry    (cfg_entry),
    .req          (req),
    .req_addr     (req_addr),
    .req_data     (req_data)
  );

  bsp_wr_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_addr (req_addr),
    .req_data (req_data),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic [15:0] cfg_clk_high,
  input logic [15:0] cfg_clk_low,
  input logic [22:0] cfg_entry,
  input logic [31:0] wr_addr,
  input logic [15:0] wr_data,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        done,
  input logic        error
);

  assert_no_accept_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !in_ready);

  assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_error_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && !in_ready));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !in_ready));

  assert_halt_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> (!wr_valid && $stable(cfg_clk_high) && $stable(cfg_clk_low)
                         && $stable(cfg_entry)));

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

endmodule

bind boot_stream_parser bsp_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .cfg_clk_high (cfg_clk_high),
  .cfg_clk_low  (cfg_clk_low),
  .cfg_entry    (cfg_entry),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .done         (done),
  .error        (error)
);

// File: tb/boot_stream_parser_tb.sv
module boot_stream_parser_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  cfg_prescale;
  logic [15:0] cfg_clk_high;
  logic [15:0] cfg_clk_low;
  logic [22:0] cfg_entry;
  logic [31:0] wr_addr;
  logic [15:0] wr_data;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic        done;
  logic        error;

  int checks = 0;
  int errs = 0;
  int rdy_mode = 0;
  logic [47:0] expq[$];

  always #10 clk = ~clk;

  boot_stream_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .cfg_prescale(cfg_prescale), .cfg_clk_high(cfg_clk_high),
    .cfg_clk_low(cfg_clk_low), .cfg_entry(cfg_entry), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .done(done), .error(error)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    send_byte(w[7:0]);
    send_byte(w[15:8]);
  endtask

  task automatic send_header(input logic [7:0] psc, input logic [15:0] ckh,
                             input logic [15:0] ckl, input logic [15:0] eph,
                             input logic [15:0] epl);
    send_word(16'h08AA);
    send_byte(psc);
    send_byte(8'hE7);                          // pad byte, must be ignored (R3)
    send_word(ckh);
    send_word(ckl);
    for (int i = 0; i < 8; i++) send_word(16'hC3C0 + 16'(i));  // reserved words (R5)
    send_word(eph);
    send_word(epl);
  endtask

  // driver pushes expected writes into the scoreboard, then streams the block
  task automatic send_block(input logic [31:0] addr, input int n, input logic [15:0] seed);
    for (int k = 0; k < n; k++) expq.push_back({addr + 32'(k), seed ^ 16'(k * 16'h0111)});
    send_word(16'(n));
    send_word(addr[31:16]);
    send_word(addr[15:0]);
    for (int k = 0; k < n; k++) send_word(seed ^ 16'(k * 16'h0111));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // write-side ready pattern, driven away from the sampling edge
  initial begin
    logic [7:0] lfsr = 8'hA5;
    forever begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
    end
  end

  // monitor: scoreboard compare and backpressure rules (R7, R9)
  initial begin
    logic        held = 1'b0;
    logic [47:0] prev = '0;
    logic [47:0] e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (wr_valid && in_ready) chk("R9 in_ready while write pending", 32'(in_ready), 32'h0);
        if (held) begin
          chk("R9 held write address", wr_addr, prev[47:16]);
          chk("R9 held write data", 32'(wr_data), 32'(prev[15:0]));
        end
        if (wr_valid && wr_ready) begin
          if (expq.size() == 0) begin
            chk("R9 unexpected write", wr_addr, 32'hFFFF_FFFF);
          end else begin
            e = expq.pop_front();
            chk("R7 write address", wr_addr, e[47:16]);
            chk("R7 write data", 32'(wr_data), 32'(e[15:0]));
          end
        end
        held = wr_valid && !wr_ready;
        prev = {wr_addr, wr_data};
      end else begin
        held = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 in_ready", 32'(in_ready), 32'h1);
    chk("R1 wr_valid", 32'(wr_valid), 32'h0);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 error", 32'(error), 32'h0);
    chk("R1 config", {cfg_prescale, cfg_clk_high, 8'h0} | 32'(cfg_clk_low) | 32'(cfg_entry), 32'h0);

    // clean stream with toggling write ready
    rdy_mode = 1;
    send_header(8'h5C, 16'h1234, 16'hABCD, 16'h00C5, 16'hBEEF);
    @(negedge clk);
    chk("R2 no error on good key", 32'(error), 32'h0);
    chk("R3 prescaler", 32'(cfg_prescale), 32'h5C);
    chk("R4 clock high", 32'(cfg_clk_high), 32'h1234);
    chk("R4 clock low", 32'(cfg_clk_low), 32'hABCD);
    chk("R5 R6 entry after reserved words", 32'(cfg_entry), 32'h45BEEF);
    send_block(32'h0001_FFFE, 3, 16'h9A51);   // carry across 16-bit boundary (R7)
    send_block(32'h8000_0000, 1, 16'h0F0F);
    send_word(16'h0000);
    @(negedge clk);
    chk("R8 done", 32'(done), 32'h1);
    chk("R8 in_ready low", 32'(in_ready), 32'h0);
    repeat (4) @(negedge clk);
    chk("R7 all writes seen", 32'(expq.size()), 32'h0);
    // R10: stimulus after done must not reach the ports
    in_valid = 1'b1;
    in_data  = 8'h11;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 no write after done", 32'(wr_valid), 32'h0);
      chk("R10 ready stays low", 32'(in_ready), 32'h0);
    end
    in_valid = 1'b0;
    chk("R10 config held", 32'(cfg_clk_low), 32'hABCD);

    // long backpressure stall
    do_reset();
    rdy_mode = 0;
    send_header(8'h01, 16'h0002, 16'h0003, 16'h0000, 16'h0004);
    rdy_mode = 2;
    fork
      send_block(32'h0000_0100, 2, 16'h7E00);
      begin
        repeat (60) @(negedge clk);
        chk("R9 stalled with pending write", {30'h0, wr_valid, in_ready}, 32'h2);
        rdy_mode = 0;
      end
    join
    send_word(16'h0000);
    @(negedge clk);
    chk("R8 done after stall", 32'(done), 32'h1);
    repeat (3) @(negedge clk);
    chk("R9 no lost or extra word", 32'(expq.size()), 32'h0);

    // wrong key value
    do_reset();
    send_word(16'h09AA);
    @(negedge clk);
    chk("R2 error on bad key", 32'(error), 32'h1);
    chk("R2 in_ready low after error", 32'(in_ready), 32'h0);
    chk("R2 done stays low", 32'(done), 32'h0);

    // right bytes, swapped order
    do_reset();
    send_byte(8'h08);
    send_byte(8'hAA);
    @(negedge clk);
    chk("R2 error on swapped key bytes", 32'(error), 32'h1);
    in_valid = 1'b1;
    in_data  = 8'h5C;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    chk("R10 config untouched after error", 32'(cfg_prescale), 32'h0);
    chk("R10 no write after error", 32'(wr_valid), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule